// File: doc/BRIEF.md
# Eight-Region Memory Protection Checker

This block decides, in the same cycle, whether a processor load, store or instruction fetch may go ahead. The address space is covered by eight programmable regions. Each region has a power-of-two size with a 64-byte minimum grain, a base address aligned to that size, and a pair of 4-bit permission codes: one for data accesses and one for instruction fetches. Each code grants rights to the user level and to the privileged level separately. The privilege level comes from the processor mode field: one mode value means user, and every other value means privileged.

Software programs the regions, both permission words and a global enable through a simple write port. After any write to a region or permission register, the block computes a mask and match pair for every region and for each of the six combinations of access kind and privilege. The results are held in a table, so the per-access check is only an AND, a compare and an OR-reduce. When the global enable is off, every access is allowed.

Top module: `mpu_region_check`

## Requirements
- R1: After reset, protection is disabled and every table entry is the never-hit pair (mask zero, match all ones), so `chk_allow` is 1 for every access.
- R2: A write with `cfg_we` high goes to the register named by `cfg_sel`. Selects 0 to 7 are region registers 0 to 7, select 8 is the data permission word, select 9 is the fetch permission word and select 10 is the control register. Selects 11 to 15 change nothing.
- R3: While control bit 0 is clear, `chk_allow` is 1 for every address, kind and mode.
- R4: In a region register, bit 0 is the enable and bits [5:1] hold an exponent N. The region spans 2^(N+1) bytes but never less than 64 bytes. It hits when the address and the register agree on every bit at or above the larger of N+1 and 6.
- R5: A region with exponent 31 covers the whole 32-bit space and hits every address.
- R6: Data code per region. 1 gives privileged read and write and no user access. 2 gives privileged read and write and user read. 3 gives read and write at both levels. 5 gives privileged read only. 6 gives read only at both levels. 0, 4 and 7 to 15 grant nothing.
- R7: Fetch code per region. 1 and 5 allow privileged fetch only. 2, 3 and 6 allow fetch at both levels. 0, 4 and 7 to 15 allow no fetch.
- R8: An access is a user access when `chk_mode` equals 5'h10. Every other mode value is privileged.
- R9: With protection on, the access is allowed when at least one enabled region hits and grants the access at the current level. Otherwise it faults. A disabled region never hits.
- R10: A write to a region or permission register reaches the table at the next clock edge. Checks in the cycle right after the write still see the old table. A write to the control register takes effect at the edge that takes it.
- R11: `chk_kind` encodes 0 as write, 1 as read and 2 as fetch. Code 3 is denied whenever protection is on.
- R12: The permission code for region n is bits [4n+3:4n] of the data or fetch permission word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Register select for the write |
| cfg_wdata | input | 32 | Write data |
| chk_addr | input | 32 | Address of the access being checked |
| chk_kind | input | 2 | Access kind: 0 write, 1 read, 2 fetch, 3 none |
| chk_mode | input | 5 | Processor mode field |
| chk_allow | output | 1 | 1 when the access is permitted, 0 on a protection fault |

## Verification
The check is first tried with protection off and with no region enabled. These two cases separate the enable path from the region logic. Single regions are then placed at sizes from the 64-byte grain up to the whole space, and probes sit just inside and just outside each boundary, so an error in the mask derivation shows up as a one-off edge. Every data and fetch code is swept under a user mode and several privileged modes. This separates the level split from the read/write split and exposes any code decoded in the wrong nibble. Back-to-back writes followed by immediate probes pin the one-cycle table latency. A random phase mixes region layouts, permission words and unmapped selects.

// File: rtl/mpu_pkg.sv
package mpu_pkg;

  localparam int ACC_CODES = 6;

  typedef enum logic [1:0] {
    KIND_WRITE = 2'd0,
    KIND_READ  = 2'd1,
    KIND_FETCH = 2'd2,
    KIND_NONE  = 2'd3
  } acc_kind_e;

  // Data permission: grant for a given level and direction.
  function automatic logic data_grant(input logic [3:0] code,
                                      input logic priv,
                                      input logic is_write);
    logic g;
    case (code)
      4'd1:    g = priv;
      4'd2:    g = priv | ~is_write;
      4'd3:    g = 1'b1;
      4'd5:    g = priv & ~is_write;
      4'd6:    g = ~is_write;
      default: g = 1'b0;
    endcase
    return g;
  endfunction

  // Fetch permission: grant for a given level.
  function automatic logic fetch_grant(input logic [3:0] code,
                                       input logic priv);
    logic g;
    case (code)
      4'd1, 4'd5:       g = priv;
      4'd2, 4'd3, 4'd6: g = 1'b1;
      default:          g = 1'b0;
    endcase
    return g;
  endfunction

  // Access code index: {kind, priv}; kinds write, read and fetch give 0..5.
  function automatic logic code_grant(input int acc,
                                      input logic [3:0] dcode,
                                      input logic [3:0] icode);
    logic priv;
    logic g;
    priv = acc[0];
    case (acc >> 1)
      0:       g = data_grant(dcode, priv, 1'b1);
      1:       g = data_grant(dcode, priv, 1'b0);
      2:       g = fetch_grant(icode, priv);
      default: g = 1'b0;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/mpu_rst_sync.sv
module mpu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/mpu_cfg_regs.sv
module mpu_cfg_regs #(
  parameter int ADDR_W      = 32,
  parameter int NUM_REGIONS = 8,
  parameter int PERM_W      = 4,
  parameter int SEL_W       = 4,
  localparam int PERM_REG_W = NUM_REGIONS * PERM_W
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  cfg_we,
  input  logic [SEL_W-1:0]                      cfg_sel,
  input  logic [ADDR_W-1:0]                     cfg_wdata,
  output logic [NUM_REGIONS-1:0][ADDR_W-1:0]    region_q,
  output logic [PERM_REG_W-1:0]                 dperm_q,
  output logic [PERM_REG_W-1:0]                 iperm_q,
  output logic                                  prot_en_q,
  output logic                                  recalc_q
);

  localparam int SEL_DPERM = NUM_REGIONS;
  localparam int SEL_IPERM = NUM_REGIONS + 1;
  localparam int SEL_CTRL  = NUM_REGIONS + 2;

  logic [NUM_REGIONS-1:0][ADDR_W-1:0] region_d;
  logic [PERM_REG_W-1:0]              dperm_d;
  logic [PERM_REG_W-1:0]              iperm_d;
  logic                               prot_en_d;
  logic                               recalc_d;

  always_comb begin
    region_d  = region_q;
    dperm_d   = dperm_q;
    iperm_d   = iperm_q;
    prot_en_d = prot_en_q;
    recalc_d  = 1'b0;
    if (cfg_we) begin
      for (int r = 0; r < NUM_REGIONS; r++) begin
        if (cfg_sel == SEL_W'(r)) region_d[r] = cfg_wdata;
      end
      if (cfg_sel == SEL_W'(SEL_DPERM)) dperm_d   = cfg_wdata[PERM_REG_W-1:0];
      if (cfg_sel == SEL_W'(SEL_IPERM)) iperm_d   = cfg_wdata[PERM_REG_W-1:0];
      if (cfg_sel == SEL_W'(SEL_CTRL))  prot_en_d = cfg_wdata[0];
      recalc_d = (cfg_sel <= SEL_W'(SEL_IPERM));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      region_q  <= '0;
      dperm_q   <= '0;
      iperm_q   <= '0;
      prot_en_q <= 1'b0;
      recalc_q  <= 1'b0;
    end else begin
      region_q  <= region_d;
      dperm_q   <= dperm_d;
      iperm_q   <= iperm_d;
      prot_en_q <= prot_en_d;
      recalc_q  <= recalc_d;
    end
  end

endmodule

// File: rtl/mpu_region_table.sv
module mpu_region_table
  import mpu_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PERM_W     = 4,
  parameter int EXP_W      = 5,
  parameter int GRAIN_LOG2 = 6
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                load,
  input  logic [ADDR_W-1:0]                   region_cfg,
  input  logic [PERM_W-1:0]                   dcode,
  input  logic [PERM_W-1:0]                   icode,
  output logic [ACC_CODES-1:0][ADDR_W-1:0]    tbl_mask,
  output logic [ACC_CODES-1:0][ADDR_W-1:0]    tbl_match
);

  localparam int SHIFT_W = EXP_W + 1;
  localparam logic [ADDR_W-1:0] GRAIN_ONES =
    {{(ADDR_W-GRAIN_LOG2){1'b0}}, {GRAIN_LOG2{1'b1}}};

  logic [EXP_W-1:0]   size_exp;
  logic [SHIFT_W-1:0] span_log2;
  logic               whole_space;
  logic [ADDR_W-1:0]  low_ones;
  logic [ADDR_W-1:0]  reg_mask;
  logic [ADDR_W-1:0]  reg_match;
  logic [ACC_CODES-1:0][ADDR_W-1:0] mask_d;
  logic [ACC_CODES-1:0][ADDR_W-1:0] match_d;

  always_comb begin
    size_exp    = region_cfg[EXP_W:1];
    span_log2   = SHIFT_W'(size_exp) + SHIFT_W'(1);
    whole_space = (span_log2 >= SHIFT_W'(ADDR_W));
    low_ones    = ~({ADDR_W{1'b1}} << span_log2);
    if (whole_space) begin
      reg_mask  = '0;
      reg_match = '0;
    end else begin
      reg_mask  = ~(low_ones | GRAIN_ONES);
      reg_match = region_cfg & reg_mask;
    end
  end

  for (genvar c = 0; c < ACC_CODES; c++) begin : g_code
    logic grant;
    always_comb begin
      grant      = region_cfg[0] & code_grant(c, dcode, icode);
      mask_d[c]  = grant ? reg_mask  : '0;
      match_d[c] = grant ? reg_match : '1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_mask  <= '0;
      tbl_match <= '1;
    end else if (load) begin
      tbl_mask  <= mask_d;
      tbl_match <= match_d;
    end
  end

endmodule

// File: rtl/mpu_access_match.sv
module mpu_access_match
  import mpu_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int NUM_REGIONS = 8,
  parameter int MODE_W      = 5,
  parameter logic [MODE_W-1:0] USER_MODE = 5'h10
) (
  input  logic                                                prot_en,
  input  logic [ADDR_W-1:0]                                   addr,
  input  logic [1:0]                                          kind,
  input  logic [MODE_W-1:0]                                   mode,
  input  logic [NUM_REGIONS-1:0][ACC_CODES-1:0][ADDR_W-1:0]   tbl_mask,
  input  logic [NUM_REGIONS-1:0][ACC_CODES-1:0][ADDR_W-1:0]   tbl_match,
  output logic                                                allow
);

  logic                   priv;
  logic                   kind_ok;
  logic [2:0]             acc;
  logic [NUM_REGIONS-1:0] hits;

  always_comb begin
    priv    = (mode != USER_MODE);
    kind_ok = (kind != KIND_NONE);
    acc     = kind_ok ? {kind, priv} : 3'd0;
  end

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_hit
    assign hits[r] = ((addr & tbl_mask[r][acc]) == tbl_match[r][acc]);
  end

  assign allow = ~prot_en | (kind_ok & (|hits));

endmodule

// File: rtl/mpu_region_check.sv
module mpu_region_check
  import mpu_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int NUM_REGIONS = 8,
  parameter int PERM_W      = 4,
  parameter int MODE_W      = 5,
  parameter int EXP_W       = 5,
  parameter int GRAIN_LOG2  = 6,
  parameter logic [MODE_W-1:0] USER_MODE = 5'h10,
  localparam int SEL_W      = $clog2(NUM_REGIONS + 3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic [ADDR_W-1:0] chk_addr,
  input  logic [1:0]        chk_kind,
  input  logic [MODE_W-1:0] chk_mode,
  output logic              chk_allow
);

  localparam int PERM_REG_W = NUM_REGIONS * PERM_W;

  logic                                               rst_q_n;
  logic [NUM_REGIONS-1:0][ADDR_W-1:0]                 region_q;
  logic [PERM_REG_W-1:0]                              dperm_q;
  logic [PERM_REG_W-1:0]                              iperm_q;
  logic                                               prot_en_q;
  logic                                               recalc_q;
  logic [NUM_REGIONS-1:0]                             region_en;
  logic [NUM_REGIONS-1:0][ACC_CODES-1:0][ADDR_W-1:0]  tbl_mask;
  logic [NUM_REGIONS-1:0][ACC_CODES-1:0][ADDR_W-1:0]  tbl_match;

  mpu_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  mpu_cfg_regs #(
    .ADDR_W      (ADDR_W),
    .NUM_REGIONS (NUM_REGIONS),
    .PERM_W      (PERM_W),
    .SEL_W       (SEL_W)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .region_q  (region_q),
    .dperm_q   (dperm_q),
    .iperm_q   (iperm_q),
    .prot_en_q (prot_en_q),
    .recalc_q  (recalc_q)
  );

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
    assign region_en[r] = region_q[r][0];

    mpu_region_table #(
      .ADDR_W     (ADDR_W),
      .PERM_W     (PERM_W),
      .EXP_W      (EXP_W),
      .GRAIN_LOG2 (GRAIN_LOG2)
    ) u_tbl (
      .clk        (clk),
      .rst_n      (rst_q_n),
      .load       (recalc_q),
      .region_cfg (region_q[r]),
      .dcode      (dperm_q[r*PERM_W +: PERM_W]),
      .icode      (iperm_q[r*PERM_W +: PERM_W]),
      .tbl_mask   (tbl_mask[r]),
      .tbl_match  (tbl_match[r])
    );
  end

  mpu_access_match #(
    .ADDR_W      (ADDR_W),
    .NUM_REGIONS (NUM_REGIONS),
    .MODE_W      (MODE_W),
    .USER_MODE   (USER_MODE)
  ) u_match (
    .prot_en   (prot_en_q),
    .addr      (chk_addr),
    .kind      (chk_kind),
    .mode      (chk_mode),
    .tbl_mask  (tbl_mask),
    .tbl_match (tbl_match),
    .allow     (chk_allow)
  );

endmodule

// File: rtl/mpu_region_check_sva.sv
module mpu_region_check_sva #(
  parameter int NUM_REGIONS = 8,
  parameter int SEL_W       = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cfg_we,
  input logic [SEL_W-1:0]       cfg_sel,
  input logic                   wdata_b0,
  input logic [1:0]             chk_kind,
  input logic                   chk_allow,
  input logic                   prot_en,
  input logic [NUM_REGIONS-1:0] region_en,
  input logic                   recalc
);

  localparam int SEL_CTRL = NUM_REGIONS + 2;

  // R3: protection off lets everything through
  a_r3_off_allows: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_en |-> chk_allow);

  // R11: the unused kind is refused once protection is on
  a_r11_none_kind_denied: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_en && chk_kind == 2'd3) |-> !chk_allow);

  // R9: no enabled region and a settled table means a fault
  a_r9_no_region_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_en && region_en == '0 && !recalc) |-> !chk_allow);

  // R2: a control write lands one edge later
  a_r2_ctrl_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == SEL_W'(SEL_CTRL)) |=> (prot_en == $past(wdata_b0)));

  // R10: a region or permission write schedules a table reload
  a_r10_reload_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel < SEL_W'(SEL_CTRL)) |=> recalc);

  // R2: unmapped selects change nothing
  a_r2_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel > SEL_W'(SEL_CTRL)) |=> (!recalc && $stable(prot_en) && $stable(region_en)));

endmodule

bind mpu_region_check mpu_region_check_sva #(
  .NUM_REGIONS (NUM_REGIONS),
  .SEL_W       (SEL_W)
) u_sva (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .cfg_we    (cfg_we),
  .cfg_sel   (cfg_sel),
  .wdata_b0  (cfg_wdata[0]),
  .chk_kind  (chk_kind),
  .chk_allow (chk_allow),
  .prot_en   (prot_en_q),
  .region_en (region_en),
  .recalc    (recalc_q)
);

// File: tb/mpu_region_check_bench.sv
`timescale 1ns/1ps
module mpu_region_check_bench;

  localparam int WATCHDOG_CYC = 150000;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic [31:0] chk_addr;
  logic [1:0]  chk_kind;
  logic [4:0]  chk_mode;
  logic        chk_allow;

  int    n_checks;
  int    n_fail;
  bit    done;
  string cur_tag;

  mpu_region_check u_mpu_region_check (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .chk_addr  (chk_addr),
    .chk_kind  (chk_kind),
    .chk_mode  (chk_mode),
    .chk_allow (chk_allow)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // ---------------- behavioural reference model ----------------
  bit [31:0] m_reg  [8];
  bit [31:0] m_eff  [8];
  bit [31:0] m_dp, m_ip, m_eff_dp, m_eff_ip;
  bit        m_ctrl;
  bit        m_pend;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin m_reg[i] = 0; m_eff[i] = 0; end
      m_dp = 0; m_ip = 0; m_eff_dp = 0; m_eff_ip = 0;
      m_ctrl = 0; m_pend = 0;
    end else begin
      if (m_pend) begin
        for (int i = 0; i < 8; i++) m_eff[i] = m_reg[i];
        m_eff_dp = m_dp;
        m_eff_ip = m_ip;
      end
      m_pend = cfg_we && (cfg_sel <= 9);
      if (cfg_we) begin
        if (cfg_sel < 8)        m_reg[cfg_sel] = cfg_wdata;
        else if (cfg_sel == 8)  m_dp   = cfg_wdata;
        else if (cfg_sel == 9)  m_ip   = cfg_wdata;
        else if (cfg_sel == 10) m_ctrl = cfg_wdata[0];
      end
    end
  end

  function automatic bit m_perm(int code, int kind, bit priv);
    if (kind == 0) return priv ? (code >= 1 && code <= 3) : (code == 3);
    return priv ? (code == 1 || code == 2 || code == 3 || code == 5 || code == 6)
                : (code == 2 || code == 3 || code == 6);
  endfunction

  function automatic bit m_allow(bit [31:0] addr, int kind, bit [4:0] mode);
    bit priv;
    if (!m_ctrl) return 1;
    if (kind == 3) return 0;
    priv = (mode != 5'h10);
    for (int r = 0; r < 8; r++) begin
      int n, sh, code;
      bit hit;
      if (!m_eff[r][0]) continue;
      n  = int'(m_eff[r][5:1]);
      sh = (n + 1 < 6) ? 6 : n + 1;
      hit = (sh >= 32) ? 1'b1 : ((addr >> sh) == (m_eff[r] >> sh));
      code = (kind == 2) ? int'((m_eff_ip >> (4*r)) & 4'hF)
                         : int'((m_eff_dp >> (4*r)) & 4'hF);
      if (hit && m_perm(code, kind, priv)) return 1;
    end
    return 0;
  endfunction

  // compare every cycle, well after inputs change and before the next edge
  always begin
    @(negedge clk);
    #3;
    if (rst_n && !done) begin
      bit exp_v;
      exp_v = m_allow(chk_addr, int'(chk_kind), chk_mode);
      n_checks++;
      if (chk_allow !== exp_v) begin
        n_fail++;
        $display("FAIL %s addr=%h kind=%0d mode=%h actual=%b expected=%b",
                 cur_tag, chk_addr, chk_kind, chk_mode, chk_allow, exp_v);
      end
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic wr(input int sel, input bit [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 4'(sel); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic probe(input bit [31:0] addr, input int kind, input bit [4:0] mode);
    @(negedge clk);
    chk_addr = addr; chk_kind = 2'(kind); chk_mode = mode;
  endtask

  task automatic sweep(input bit [31:0] addr);
    bit [4:0] modes [4] = '{5'h10, 5'h1F, 5'h13, 5'h00};
    for (int k = 0; k < 4; k++)
      for (int m = 0; m < 4; m++) probe(addr, k, modes[m]);
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  // ---------------- test sequence ----------------
  initial begin
    n_checks = 0; n_fail = 0; done = 0;
    cur_tag = "R1";
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    chk_addr = 32'h1234_5678; chk_kind = 2'd3; chk_mode = 5'h10;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: explicit reset-state check
    #3;
    n_checks++;
    if (chk_allow !== 1'b1) begin
      n_fail++;
      $display("FAIL R1 reset allow actual=%b expected=1", chk_allow);
    end
    sweep(32'h0000_0000); sweep(32'hFFFF_FFC0);

    // R3: regions programmed, protection still off
    cur_tag = "R3";
    wr(0, 32'h0000_1001);
    wr(8, 32'h0000_0000);
    settle();
    sweep(32'h0000_1000); sweep(32'h8000_0000);

    // R9: protection on, no region enabled
    cur_tag = "R9";
    wr(0, 32'h0000_1000);
    wr(10, 32'h1);
    settle();
    sweep(32'h0000_1000); sweep(32'h0000_0000);

    // R4: 16 KB region at 0x0200_0000, full rights, region 1
    cur_tag = "R4";
    wr(1, 32'h0200_0000 | (13 << 1) | 1);
    wr(8, 32'h0000_0030);
    wr(9, 32'h0000_0030);
    settle();
    sweep(32'h0200_0000); sweep(32'h0200_3FFF);
    sweep(32'h0200_4000); sweep(32'h01FF_FFFF);
    // minimum grain: exponent 2 still spans 64 bytes, region 2
    wr(2, 32'h0000_0100 | (2 << 1) | 1);
    wr(8, 32'h0000_0330);
    wr(9, 32'h0000_0330);
    settle();
    sweep(32'h0000_0100); sweep(32'h0000_013F);
    sweep(32'h0000_0140); sweep(32'h0000_00FF);

    // R5: whole-space region 7 with user read-only data, no fetch
    cur_tag = "R5";
    wr(7, 32'h0000_003F);
    wr(8, 32'h6000_0330);
    wr(9, 32'h0000_0330);
    settle();
    sweep(32'hDEAD_BEEF); sweep(32'h0000_0000); sweep(32'hFFFF_FFFF);
    wr(7, 32'h0);

    // R6: every data code on region 1
    cur_tag = "R6";
    for (int c = 0; c < 16; c++) begin
      wr(8, 32'(c) << 4);
      settle();
      sweep(32'h0200_0040);
    end

    // R7: every fetch code on region 1
    cur_tag = "R7";
    for (int c = 0; c < 16; c++) begin
      wr(9, 32'(c) << 4);
      settle();
      sweep(32'h0200_1000);
    end

    // R8: mode decode around the user value
    cur_tag = "R8";
    wr(8, 32'h0000_0010);
    settle();
    for (int m = 0; m < 32; m++) begin
      probe(32'h0200_0000, 0, 5'(m));
      probe(32'h0200_0000, 1, 5'(m));
    end

    // R10: probes right after writes see the old table
    cur_tag = "R10";
    wr(1, 32'h0200_0000 | (13 << 1) | 1);
    wr(8, 32'h0000_0030);
    probe(32'h0200_0000, 1, 5'h10);
    wr(1, 32'h0200_0000);
    probe(32'h0200_0000, 1, 5'h10);
    probe(32'h0200_0000, 1, 5'h10);
    wr(1, 32'h0200_0000 | (13 << 1) | 1);
    probe(32'h0200_0000, 1, 5'h1F);
    wr(10, 32'h0);
    probe(32'h0300_0000, 3, 5'h10);
    wr(10, 32'h1);
    probe(32'h0300_0000, 1, 5'h10);

    // R2: unmapped selects change nothing
    cur_tag = "R2";
    for (int s = 11; s < 16; s++) begin
      wr(s, 32'h0000_0000);
      sweep(32'h0200_0000);
    end

    // R11: kind 3 with protection on and a full-rights region
    cur_tag = "R11";
    probe(32'h0200_0000, 3, 5'h1F);
    probe(32'h0200_0000, 3, 5'h10);

    // R12: each region holds its own nibble
    cur_tag = "R12";
    for (int r = 0; r < 8; r++) begin
      wr(r, (32'(r) << 24) | (11 << 1) | 1);
    end
    wr(8, 32'h6521_3601);
    wr(9, 32'h1253_0162);
    settle();
    for (int r = 0; r < 8; r++) sweep((32'(r) << 24) | 32'h0000_0200);

    // random mix
    cur_tag = "R12";
    for (int it = 0; it < 400; it++) begin
      int sel;
      bit [31:0] d;
      sel = int'($urandom_range(0, 15));
      d   = $urandom;
      if (sel == 10) d[0] = ($urandom_range(0, 3) != 0);
      wr(sel, d);
      for (int p = 0; p < 6; p++) begin
        int r;
        r = int'($urandom_range(0, 7));
        probe(m_reg[r] ^ ($urandom & 32'h0000_7FFF),
              int'($urandom_range(0, 3)),
              ($urandom_range(0, 1) != 0) ? 5'h10 : 5'(($urandom)));
      end
    end

    repeat (2) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule